// File: doc/BRIEF.md
# Flash Byte-Program Sequencer

This block sits on the host side of a parallel NOR flash with an 8-bit data bus. It writes a run of bytes into the flash one byte at a time. A one-cycle start pulse supplies a start address and a byte count. For every byte the block first takes one byte from a valid/ready data source. It then sends the flash the fixed command preamble followed by the address/data write. Next it reads the device status until the internal program step reports completion. A final read confirms the whole byte before the address advances.

Every flash access is a bus cycle with a fixed length set by a parameter. Chip enable is held for the whole access. The write strobe covers only the inner cycles, which leaves setup and hold margin on both sides. Two events stop a run early: the device raising its timeout status bit, or a byte that reads back wrong. In both cases the block writes the device's reset command so the array is readable again, latches the failing address, sets a sticky error flag and then signals done.

Top module: `flash_prog_seq`

## Requirements
- R1: While reset is asserted and afterwards until the first start, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are high, and `src_ready`, `busy`, `done` and `error` are low.
- R2: Each byte is written with exactly four bus writes, in this order: (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0xA0), then (target address, data byte). A successful run issues no other writes.
- R3: After the data write the block only reads the target address, and issues no writes, until read bit 7 equals bit 7 of the data byte. Each status read that differs in bit 7 (with bit 5 low) causes one more read.
- R4: Once bit 7 matches, the block performs one more read of the target address. If this read differs from the data byte in any bit, the block sets `error`, sets `err_addr` to that address, writes 0xF0 and ends the run.
- R5: When a byte verifies, the address advances by one. After the byte at start address + length - 1 verifies, `done` pulses high for exactly one cycle. Exactly `length` source bytes are consumed.
- R6: A status read with bit 5 high and bit 7 not matching ends the run. The block sets `error` and `err_addr` to the failing address, and issues one write of 0xF0 before `done`.
- R7: Addresses wrap modulo 2^AW, and no boundary inside the array gets special treatment.
- R8: A start with length 0 pulses `done` without any bus access and without consuming a source byte.
- R9: Every access lasts ACC_CYC cycles with `fl_ce_n` low throughout. On a write, `fl_we_n` is low for exactly ACC_CYC-2 cycles, beginning one cycle after `fl_ce_n` falls and ending one cycle before it rises. On a read, `fl_oe_n` is low. `fl_we_n` and `fl_oe_n` are never low together.
- R10: `src_ready` is high only while the block waits for the next byte. A byte is taken on a cycle where both `src_valid` and `src_ready` are high. The flash bus stays idle while the block waits.
- R11: A start pulse while `busy` is high is ignored.
- R12: `error` holds its value until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a run |
| start_addr | input | AW | First flash address of the run |
| length | input | AW+1 | Number of bytes to program |
| src_valid | input | 1 | Source byte is present |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | Block accepts a source byte |
| fl_addr | output | AW | Flash address bus |
| fl_dout | output | 8 | Data driven to the flash on writes |
| fl_din | input | 8 | Data returned by the flash on reads |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| error | output | 1 | Sticky failure flag of the last run |
| err_addr | output | AW | Address of the byte that failed |

## Verification
Some properties are checked on every cycle. The write strobe stays nested inside chip enable and never overlaps output enable. The bus is quiet whenever the block is idle or waiting for source data. No write occurs while it polls. `done` lasts one cycle, and `error` only falls after a start. Other behaviour can only be shown by the bench's scenarios, which use a behavioural flash model. These cover the exact command order and the number of status reads per byte, the verify failure on a byte with stuck-low bits, and recovery from a timeout through the reset write. They also cover address wrap, the zero-length run, source stalls and a start that arrives while busy.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_CMD,
        S_POLL,
        S_VERIFY,
        S_RESET,
        S_FIN
    } seq_state_e;

    typedef enum logic [1:0] {
        PR_WAIT,
        PR_DONE,
        PR_FAIL
    } poll_res_e;

    localparam logic [7:0] CMD_UNLOCK1 = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK2 = 8'h55;
    localparam logic [7:0] CMD_PROG    = 8'hA0;
    localparam logic [7:0] CMD_RESET   = 8'hF0;

endpackage

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle #(
    parameter int ACC_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic is_wr,
    output logic ack,
    output logic ce_n,
    output logic we_n,
    output logic oe_n
);
    localparam int CW = (ACC_CYC > 2) ? $clog2(ACC_CYC) : 2;
    localparam logic [CW-1:0] LAST = CW'(ACC_CYC - 1);

    typedef struct packed {
        logic          active;
        logic          wr;
        logic [CW-1:0] cnt;
    } bus_t;

    bus_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (!b_q.active) begin
            if (req) begin
                b_d.active = 1'b1;
                b_d.wr     = is_wr;
                b_d.cnt    = '0;
            end
        end else if (b_q.cnt == LAST) begin
            b_d.active = 1'b0;
        end else begin
            b_d.cnt = b_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign ack  = b_q.active && (b_q.cnt == LAST);
    assign ce_n = !b_q.active;
    assign we_n = !(b_q.active && b_q.wr && (b_q.cnt != '0) && (b_q.cnt != LAST));
    assign oe_n = !(b_q.active && !b_q.wr);

    assert_we_inside_ce_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !ce_n);
    assert_no_strobe_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !oe_n));
    assert_we_setup_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> !$past(ce_n));
    assert_we_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> !ce_n);

endmodule

// File: rtl/flash_poll_eval.sv
module flash_poll_eval
    import flash_prog_pkg::*;
#(
    parameter int POLL_BIT = 7,
    parameter int FAIL_BIT = 5
) (
    input  logic [7:0] rd_data,
    input  logic [7:0] tgt,
    output poll_res_e  outcome,
    output logic       exact
);
    always_comb begin
        if (rd_data[POLL_BIT] == tgt[POLL_BIT]) outcome = PR_DONE;
        else if (rd_data[FAIL_BIT])             outcome = PR_FAIL;
        else                                    outcome = PR_WAIT;
    end

    assign exact = (rd_data == tgt);
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import flash_prog_pkg::*;
#(
    parameter int          AW      = 12,
    parameter int          ACC_CYC = 4,
    parameter logic [AW-1:0] UNL_A1 = AW'(12'h555),
    parameter logic [AW-1:0] UNL_A2 = AW'(12'h2AA)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [AW:0]   length,
    input  logic          src_valid,
    input  logic [7:0]    src_data,
    output logic          src_ready,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dout,
    input  logic [7:0]    fl_din,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic [AW-1:0] err_addr
);
    typedef struct packed {
        seq_state_e    st;
        logic [1:0]    step;
        logic [AW-1:0] addr;
        logic [AW:0]   remain;
        logic [7:0]    tgt;
        logic          req;
        logic          wr;
        logic [AW-1:0] baddr;
        logic [7:0]    bdata;
        logic          done;
        logic          err;
        logic [AW-1:0] eaddr;
    } regs_t;

    regs_t r_d, r_q;

    logic      ack;
    poll_res_e outcome;
    logic      exact;

    flash_bus_cycle #(.ACC_CYC(ACC_CYC)) u_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (r_q.req),
        .is_wr (r_q.wr),
        .ack   (ack),
        .ce_n  (fl_ce_n),
        .we_n  (fl_we_n),
        .oe_n  (fl_oe_n)
    );

    flash_poll_eval #(.POLL_BIT(7), .FAIL_BIT(5)) u_eval (
        .rd_data (fl_din),
        .tgt     (r_q.tgt),
        .outcome (outcome),
        .exact   (exact)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        src_ready = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.err    = 1'b0;
                    r_d.addr   = start_addr;
                    r_d.remain = length;
                    r_d.st     = (length == '0) ? S_FIN : S_FETCH;
                end
            end
            S_FETCH: begin
                src_ready = 1'b1;
                if (src_valid) begin
                    r_d.tgt   = src_data;
                    r_d.st    = S_CMD;
                    r_d.step  = 2'd0;
                    r_d.req   = 1'b1;
                    r_d.wr    = 1'b1;
                    r_d.baddr = UNL_A1;
                    r_d.bdata = CMD_UNLOCK1;
                end
            end
            S_CMD: begin
                if (ack) begin
                    r_d.step = r_q.step + 2'd1;
                    unique case (r_q.step)
                        2'd0: begin
                            r_d.baddr = UNL_A2;
                            r_d.bdata = CMD_UNLOCK2;
                        end
                        2'd1: begin
                            r_d.baddr = UNL_A1;
                            r_d.bdata = CMD_PROG;
                        end
                        2'd2: begin
                            r_d.baddr = r_q.addr;
                            r_d.bdata = r_q.tgt;
                        end
                        default: begin
                            r_d.st    = S_POLL;
                            r_d.wr    = 1'b0;
                            r_d.baddr = r_q.addr;
                        end
                    endcase
                end
            end
            S_POLL: begin
                if (ack) begin
                    unique case (outcome)
                        PR_DONE: r_d.st = S_VERIFY;
                        PR_FAIL: begin
                            r_d.err   = 1'b1;
                            r_d.eaddr = r_q.addr;
                            r_d.st    = S_RESET;
                            r_d.wr    = 1'b1;
                            r_d.bdata = CMD_RESET;
                        end
                        default: r_d.st = S_POLL;
                    endcase
                end
            end
            S_VERIFY: begin
                if (ack) begin
                    if (exact) begin
                        r_d.req = 1'b0;
                        if (r_q.remain == (AW+1)'(1)) begin
                            r_d.st = S_FIN;
                        end else begin
                            r_d.addr   = r_q.addr + 1'b1;
                            r_d.remain = r_q.remain - 1'b1;
                            r_d.st     = S_FETCH;
                        end
                    end else begin
                        r_d.err   = 1'b1;
                        r_d.eaddr = r_q.addr;
                        r_d.st    = S_RESET;
                        r_d.wr    = 1'b1;
                        r_d.bdata = CMD_RESET;
                    end
                end
            end
            S_RESET: begin
                if (ack) begin
                    r_d.req = 1'b0;
                    r_d.st  = S_FIN;
                end
            end
            S_FIN: begin
                r_d.done = 1'b1;
                r_d.st   = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign fl_addr  = r_q.baddr;
    assign fl_dout  = r_q.bdata;
    assign busy     = (r_q.st != S_IDLE);
    assign done     = r_q.done;
    assign error    = r_q.err;
    assign err_addr = r_q.eaddr;

    assert_idle_bus_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_IDLE) |-> (fl_ce_n && fl_we_n && fl_oe_n));
    assert_no_write_while_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_POLL) |-> fl_we_n);
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_wait_bus_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> fl_ce_n);
    assert_error_clears_on_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(error) |-> $past(start));

endmodule

// File: tb/flash_prog_seq_test.sv
module flash_prog_seq_test;
    localparam int AW      = 12;
    localparam int ACC_CYC = 4;
    localparam int AMASK   = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [AW:0]   length = '0;
    logic          src_valid = 1'b0;
    logic [7:0]    src_data = '0;
    logic          src_ready;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_dout;
    logic [7:0]    fl_din;
    logic          fl_ce_n, fl_we_n, fl_oe_n;
    logic          busy, done, error;
    logic [AW-1:0] err_addr;

    always #2 clk = ~clk;

    flash_prog_seq #(.AW(AW), .ACC_CYC(ACC_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .length(length), .src_valid(src_valid), .src_data(src_data),
        .src_ready(src_ready), .fl_addr(fl_addr), .fl_dout(fl_dout),
        .fl_din(fl_din), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
        .fl_oe_n(fl_oe_n), .busy(busy), .done(done), .error(error),
        .err_addr(err_addr)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    logic [7:0] mem [int];
    logic [7:0] rd_val = 8'hFF;
    assign fl_din = rd_val;

    int   f_mode = 0;        // 0 none, 1 stuck-low nibble, 2 timeout
    int   f_addr = -1;
    int   busy_cfg = 0;
    int   ucnt = 0;
    bit   m_busy = 0;
    int   busy_left = 0;
    int   st_reads = 0;
    bit   to_flag = 0;
    bit   tog = 0;
    int   m_addr = 0;
    logic [7:0] m_tgt = '0;
    int   n_prog = 0, n_reads = 0, n_resets = 0, n_proto = 0;
    int   we_cur = 0, we_min = 1000, we_max = 0;
    bit   we_prev = 1, oe_prev = 1;

    function automatic logic [7:0] rdmem(input int a);
        return mem.exists(a) ? mem[a] : 8'hFF;
    endfunction

    task automatic model_write(input int a, input logic [7:0] d);
        if (m_busy) begin
            if (d == 8'hF0 && to_flag) begin
                m_busy = 0; to_flag = 0; ucnt = 0; n_resets++;
            end else n_proto++;
        end else if (d == 8'hF0) begin
            ucnt = 0; n_resets++;
        end else begin
            case (ucnt)
                0: if (a == 'h555 && d == 8'hAA) ucnt = 1; else begin n_proto++; ucnt = 0; end
                1: if (a == 'h2AA && d == 8'h55) ucnt = 2; else begin n_proto++; ucnt = 0; end
                2: if (a == 'h555 && d == 8'hA0) ucnt = 3; else begin n_proto++; ucnt = 0; end
                default: begin
                    n_prog++; ucnt = 0; m_addr = a; m_tgt = d;
                    if (f_mode == 2 && a == f_addr) begin
                        m_busy = 1; st_reads = 0;
                    end else if (busy_cfg == 0) begin
                        mem[a] = rdmem(a) & d;
                    end else begin
                        m_busy = 1; busy_left = busy_cfg;
                    end
                end
            endcase
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (!fl_we_n) we_cur++;
            else if (we_cur > 0) begin
                if (we_cur < we_min) we_min = we_cur;
                if (we_cur > we_max) we_max = we_cur;
                we_cur = 0;
            end
            if (!fl_we_n && we_prev) model_write(int'(fl_addr), fl_dout);
            if (!fl_oe_n && oe_prev) begin
                n_reads++;
                if (m_busy) begin
                    rd_val = {~m_tgt[7], tog, to_flag, 5'b0};
                    tog = ~tog;
                    if (f_mode == 2 && m_addr == f_addr) begin
                        st_reads++;
                        if (st_reads >= 2) to_flag = 1;
                    end else begin
                        busy_left--;
                        if (busy_left <= 0) begin
                            mem[m_addr] = rdmem(m_addr) & m_tgt;
                            m_busy = 0;
                        end
                    end
                end else rd_val = rdmem(int'(fl_addr));
            end
            we_prev = fl_we_n;
            oe_prev = fl_oe_n;
        end
    end

    // ---------------- data source ----------------
    logic [7:0] feed [16];
    int  feed_idx = 0, feed_len = 0, gap_cfg = 0, gapcnt = 0;
    bit  hs_pending = 0;

    initial begin
        forever begin
            @(negedge clk);
            if (hs_pending) begin
                feed_idx++; src_valid = 0; gapcnt = gap_cfg; hs_pending = 0;
            end
            if (!src_valid && feed_idx < feed_len) begin
                if (gapcnt == 0) begin
                    src_valid = 1; src_data = feed[feed_idx];
                end else gapcnt--;
            end
            if (src_valid && src_ready) hs_pending = 1;
        end
    end

    function automatic logic [7:0] dat(input int s, input int k);
        int v;
        v = (k * 'h17 + s * 'h31 + 'h40) & 'hF0;
        return 8'(v | 'h0A);
    endfunction

    // ---------------- scenarios ----------------
    typedef struct packed {
        logic [11:0] addr;
        logic [12:0] len;
        logic [3:0]  busy;
        logic [3:0]  gap;
        logic [1:0]  fault;
        logic [3:0]  fidx;
    } scen_t;

    localparam scen_t SCN [7] = '{
        '{addr: 12'h010, len: 13'd4, busy: 4'd3, gap: 4'd0, fault: 2'd0, fidx: 4'd0},
        '{addr: 12'h7FE, len: 13'd3, busy: 4'd0, gap: 4'd2, fault: 2'd0, fidx: 4'd0},
        '{addr: 12'hFFE, len: 13'd4, busy: 4'd1, gap: 4'd1, fault: 2'd0, fidx: 4'd0},
        '{addr: 12'h100, len: 13'd5, busy: 4'd2, gap: 4'd0, fault: 2'd1, fidx: 4'd2},
        '{addr: 12'h200, len: 13'd4, busy: 4'd5, gap: 4'd0, fault: 2'd2, fidx: 4'd1},
        '{addr: 12'h300, len: 13'd0, busy: 4'd0, gap: 4'd0, fault: 2'd0, fidx: 4'd0},
        '{addr: 12'h400, len: 13'd2, busy: 4'd1, gap: 4'd3, fault: 2'd0, fidx: 4'd0}
    };

    bit wd_expired = 0;

    task automatic launch(input int s, input int a, input int len, input int bsy,
                          input int gap, input int fm, input int fidx);
        f_mode = fm; busy_cfg = bsy;
        f_addr = (fm != 0) ? ((a + fidx) & AMASK) : -1;
        if (fm == 1) mem[f_addr] = 8'hF0;
        n_prog = 0; n_reads = 0; n_resets = 0; n_proto = 0;
        for (int k = 0; k < 16; k++) feed[k] = dat(s, k);
        src_valid = 0; hs_pending = 0; feed_idx = 0; gap_cfg = gap; gapcnt = gap;
        feed_len = len;
        start_addr = AW'(a); length = (AW+1)'(len); start = 1;
        @(negedge clk);
        start = 0;
        chk(error == 1'b0 && busy == 1'b1, "R12 start clears error", int'(error), 0);
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic finish_check(input int s, input int a, input int len, input int bsy,
                                input int fm, input int fidx);
        int exp_bytes;
        int cyc;
        wait_done(cyc);
        chk(done == 1'b1, "R5 done seen", int'(done), 1);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R5 done one cycle", int'(done), 0);
        exp_bytes = (fm == 0) ? len : fidx + 1;
        chk(n_prog == exp_bytes, "R2 program writes", n_prog, exp_bytes);
        chk(n_proto == 0, "R2 command order", n_proto, 0);
        chk(feed_idx == exp_bytes, "R5 bytes consumed", feed_idx, exp_bytes);
        if (fm == 0) begin
            chk(error == 1'b0, "R5 no error", int'(error), 0);
            chk(n_resets == 0, "R2 no reset write", n_resets, 0);
            chk(n_reads == len * (bsy + 2), "R3 poll read count", n_reads, len * (bsy + 2));
            for (int k = 0; k < len; k++) begin
                int ad;
                ad = (a + k) & AMASK;
                chk(rdmem(ad) == dat(s, k), "R7 R5 array content", int'(rdmem(ad)), int'(dat(s, k)));
            end
        end else begin
            chk(error == 1'b1, (fm == 1) ? "R4 error flag" : "R6 error flag", int'(error), 1);
            chk(int'(err_addr) == f_addr, (fm == 1) ? "R4 err_addr" : "R6 err_addr",
                int'(err_addr), f_addr);
            chk(n_resets == 1, (fm == 1) ? "R4 reset write" : "R6 reset write", n_resets, 1);
            chk(m_busy == 0, "R6 device back to array", int'(m_busy), 0);
        end
    endtask

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        chk(fl_ce_n && fl_we_n && fl_oe_n, "R1 strobes high in reset",
            int'({fl_ce_n, fl_we_n, fl_oe_n}), 7);
        chk(!src_ready && !busy && !done && !error, "R1 status low in reset",
            int'({src_ready, busy, done, error}), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(fl_ce_n && !busy && !src_ready, "R1 idle after reset",
            int'({fl_ce_n, busy, src_ready}), 'b100);

        for (int s = 0; s < 7; s++) begin
            launch(s, int'(SCN[s].addr), int'(SCN[s].len), int'(SCN[s].busy),
                   int'(SCN[s].gap), int'(SCN[s].fault), int'(SCN[s].fidx));
            if (SCN[s].len == 0) begin
                wait_done(cyc);
                chk(done == 1'b1 && cyc <= 3, "R8 zero length done", cyc, 2);
                chk(n_prog == 0 && n_reads == 0 && feed_idx == 0 && n_resets == 0,
                    "R8 no bus access", n_prog + n_reads + feed_idx, 0);
                @(negedge clk);
            end else begin
                finish_check(s, int'(SCN[s].addr), int'(SCN[s].len), int'(SCN[s].busy),
                             int'(SCN[s].fault), int'(SCN[s].fidx));
            end
            repeat (2) @(negedge clk);
        end

        // start while busy is ignored
        launch(8, 'h500, 2, 2, 0, 0, 0);
        repeat (10) @(negedge clk);
        start_addr = AW'('h600); length = (AW+1)'(3); start = 1;
        @(negedge clk);
        start = 0;
        finish_check(8, 'h500, 2, 2, 0, 0);
        chk(!mem.exists('h600), "R11 second start ignored", int'(rdmem('h600)), 'hFF);

        // source stall keeps bus idle
        launch(9, 'h700, 1, 0, 6, 0, 0);
        @(negedge clk);
        @(negedge clk);
        chk(src_ready == 1'b1 && fl_ce_n == 1'b1 && src_valid == 1'b0,
            "R10 wait with bus idle", int'({src_ready, fl_ce_n}), 3);
        finish_check(9, 'h700, 1, 0, 0, 0);

        chk(we_min == ACC_CYC - 2 && we_max == ACC_CYC - 2, "R9 write strobe width",
            we_max, ACC_CYC - 2);

        if (wd_expired) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        wd_expired = 1;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule